// File: doc/BRIEF.md
# USB OTG Wrapper Register Front-End

This block is a bus slave that sits between a host register bus and an embedded USB controller core. Each bus access is a single-cycle request with valid, write, size, address and write data. Read data and the error indication come back combinationally in the same cycle. The front end sorts each access into one of four decode regions: DIRECT, WINDOW, LOCAL or BAD. DIRECT and WINDOW accesses go to the core's register port. LOCAL accesses reach a small bank of wrapper configuration registers. BAD accesses return zero and raise an error.

The BAD region also catches misuse of the local bank: a write to a read-only register, and a write to the unsupported simulation-enable register. Any of these raises the error for that cycle. The core's interrupt level is carried to the block's interrupt output unchanged.

The block has no sequential control flow, so it has no state machine. A request never moves between regions. Classification into a region is fresh in every cycle, and only the local registers hold state. Those registers move between their reset values and software-written values on three events: a register reset, a masked write, and a soft-reset write.

Top module: `usb_otg_regfront`

## Requirements
- R1: An access with address below 0x200 (DIRECT region) drives the core port with core_valid=1. The core port carries the same address, the same size, the same direction and the same write data as the bus. bus_rdata equals core_rdata in that cycle, and bus_err stays 0.
- R2: An access with address from 0x200 to 0x3FF (WINDOW region) reaches the core at address 0x20 + ((addr >> 3) & 0x3C). Size, direction and write data are unchanged, and bus_rdata equals core_rdata.
- R3: A word read at 0x400 returns the revision value 0x33. A word read at 0x408 returns the status value 0x1, which means reset complete. Size encoding: 0 = byte, 1 = halfword, 2 = word.
- R4: A word write to 0x400 or to 0x408 raises bus_err in that cycle. It changes no register.
- R5: After reset, the word reads return the following values: 0x404 reads 0, 0x40C reads 1, 0x410 reads 0 and 0x414 reads 1.
- R6: A word write to 0x404 stores the written value ANDed with 0x301F.
- R7: A word write to 0x404 with bit 1 set first returns 0x40C to 1 and 0x414 to 1. It then stores the masked value in 0x404.
- R8: A word write to 0x40C keeps only bits [1:0]. A word write to 0x414 keeps only bit 0.
- R9: A write to 0x410 raises bus_err in that cycle, and 0x410 keeps reading 0.
- R10: Several accesses fall in the BAD region: a byte or halfword access at 0x400 or above, and any access to an address at 0x400 or above other than the six word registers 0x400 to 0x414. A BAD access returns bus_rdata=0 and raises bus_err for that cycle only. It leaves core_valid at 0.
- R11: irq_out follows core_irq at every instant, with no latching and no edge conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, same cycle |
| bus_err | output | 1 | Error for the current access |
| core_valid | output | 1 | Request to the core register port |
| core_write | output | 1 | Core access direction |
| core_size | output | 2 | Core access size |
| core_addr | output | CORE_AW (9) | Core register address |
| core_wdata | output | DATA_W (32) | Core write data |
| core_rdata | input | DATA_W (32) | Core read data, same cycle |
| core_irq | input | 1 | Core interrupt level |
| irq_out | output | 1 | Interrupt level to the system |

## Verification
The assertions check four properties on every cycle:
- a DIRECT access keeps its address at the core;
- a WINDOW access lands on an aligned core address between 0x20 and 0x5C;
- no access at 0x400 or above reaches the core;
- the error appears only with a request.

In the local bank, the assertions also check two further properties:
- the soft-reset and mask rules hold one cycle after each write;
- rejected writes leave every register unchanged.

The exact remapped addresses, the reset values, the revision and status constants, the masking of chosen data patterns and the interrupt pass-through are shown only by the bench's directed scenarios.

// File: rtl/usb_otg_regfront_pkg.sv
package usb_otg_regfront_pkg;

    typedef enum logic [1:0] {
        RGN_DIRECT,
        RGN_WINDOW,
        RGN_LOCAL,
        RGN_BAD
    } region_e;

    typedef enum logic [2:0] {
        LR_REV,
        LR_SYSCFG,
        LR_SYSSTAT,
        LR_IFSEL,
        LR_SIMEN,
        LR_STDBY,
        LR_NONE
    } lreg_e;

    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam int unsigned DIRECT_TOP = 32'h200;
    localparam int unsigned WINDOW_TOP = 32'h400;
    localparam int unsigned WIN_BASE   = 32'h20;
    localparam int unsigned WIN_MASK   = 32'h3C;
    localparam int unsigned WIN_SHIFT  = 3;

    localparam int unsigned OFF_REV     = 32'h400;
    localparam int unsigned OFF_SYSCFG  = 32'h404;
    localparam int unsigned OFF_SYSSTAT = 32'h408;
    localparam int unsigned OFF_IFSEL   = 32'h40C;
    localparam int unsigned OFF_SIMEN   = 32'h410;
    localparam int unsigned OFF_STDBY   = 32'h414;

    localparam int unsigned REV_VALUE   = 32'h33;
    localparam int unsigned STAT_VALUE  = 32'h1;
    localparam int unsigned SYSCFG_MASK = 32'h301F;
    localparam int unsigned IFSEL_MASK  = 32'h3;
    localparam int unsigned STDBY_MASK  = 32'h1;
    localparam int unsigned IFSEL_RST   = 32'h1;
    localparam int unsigned STDBY_RST   = 32'h1;
    localparam int unsigned SOFTRST_BIT = 1;

endpackage

// File: rtl/usb_otg_regfront_decode.sv
module usb_otg_regfront_decode
    import usb_otg_regfront_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int CORE_AW = 9
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [1:0]         size,
    output region_e            region,
    output lreg_e              lsel,
    output logic [CORE_AW-1:0] core_addr
);

    logic [31:0] addr_w;
    assign addr_w = 32'(addr);

    always_comb begin
        lsel = LR_NONE;
        if (addr_w < DIRECT_TOP) begin
            region = RGN_DIRECT;
        end else if (addr_w < WINDOW_TOP) begin
            region = RGN_WINDOW;
        end else if (size != SZ_WORD) begin
            region = RGN_BAD;
        end else begin
            region = RGN_LOCAL;
            unique case (addr_w)
                OFF_REV:     lsel = LR_REV;
                OFF_SYSCFG:  lsel = LR_SYSCFG;
                OFF_SYSSTAT: lsel = LR_SYSSTAT;
                OFF_IFSEL:   lsel = LR_IFSEL;
                OFF_SIMEN:   lsel = LR_SIMEN;
                OFF_STDBY:   lsel = LR_STDBY;
                default:     region = RGN_BAD;
            endcase
        end
    end

    always_comb begin
        unique case (region)
            RGN_DIRECT: core_addr = CORE_AW'(addr_w);
            RGN_WINDOW: core_addr = CORE_AW'(WIN_BASE + ((addr_w >> WIN_SHIFT) & WIN_MASK));
            default:    core_addr = '0;
        endcase
    end

endmodule

// File: rtl/usb_otg_regfront_lregs.sv
module usb_otg_regfront_lregs
    import usb_otg_regfront_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  lreg_e             sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              err
);

    logic [DATA_W-1:0] syscfg_q;
    logic [DATA_W-1:0] ifsel_q;
    logic [DATA_W-1:0] stdby_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syscfg_q <= '0;
            ifsel_q  <= DATA_W'(IFSEL_RST);
            stdby_q  <= DATA_W'(STDBY_RST);
        end else if (wr) begin
            unique case (sel)
                LR_SYSCFG: begin
                    if (wdata[SOFTRST_BIT]) begin
                        ifsel_q <= DATA_W'(IFSEL_RST);
                        stdby_q <= DATA_W'(STDBY_RST);
                    end
                    syscfg_q <= wdata & DATA_W'(SYSCFG_MASK);
                end
                LR_IFSEL: ifsel_q <= wdata & DATA_W'(IFSEL_MASK);
                LR_STDBY: stdby_q <= wdata & DATA_W'(STDBY_MASK);
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            LR_REV:     rdata = DATA_W'(REV_VALUE);
            LR_SYSCFG:  rdata = syscfg_q;
            LR_SYSSTAT: rdata = DATA_W'(STAT_VALUE);
            LR_IFSEL:   rdata = ifsel_q;
            LR_STDBY:   rdata = stdby_q;
            default:    rdata = '0;
        endcase
    end

    assign err = wr && (sel == LR_REV || sel == LR_SYSSTAT || sel == LR_SIMEN);

    assert_ifsel_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == LR_IFSEL) |=> (ifsel_q == ($past(wdata) & DATA_W'(IFSEL_MASK))));

    assert_softrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == LR_SYSCFG && wdata[SOFTRST_BIT]) |=>
        (ifsel_q == DATA_W'(IFSEL_RST) && stdby_q == DATA_W'(STDBY_RST)));

    assert_syscfg_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == LR_SYSCFG) |=> ((syscfg_q & ~DATA_W'(SYSCFG_MASK)) == '0));

    assert_ro_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (sel == LR_REV || sel == LR_SYSSTAT || sel == LR_SIMEN)) |=>
        ($stable(syscfg_q) && $stable(ifsel_q) && $stable(stdby_q)));

endmodule

// File: rtl/usb_otg_regfront.sv
module usb_otg_regfront
    import usb_otg_regfront_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int CORE_AW = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [1:0]         bus_size,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_err,
    output logic               core_valid,
    output logic               core_write,
    output logic [1:0]         core_size,
    output logic [CORE_AW-1:0] core_addr,
    output logic [DATA_W-1:0]  core_wdata,
    input  logic [DATA_W-1:0]  core_rdata,
    input  logic               core_irq,
    output logic               irq_out
);

    region_e           region;
    lreg_e             lsel;
    logic [DATA_W-1:0] local_rdata;
    logic              local_err;
    logic              local_wr;

    usb_otg_regfront_decode #(
        .ADDR_W (ADDR_W),
        .CORE_AW(CORE_AW)
    ) u_decode (
        .addr     (bus_addr),
        .size     (bus_size),
        .region   (region),
        .lsel     (lsel),
        .core_addr(core_addr)
    );

    assign local_wr = bus_valid && bus_write && (region == RGN_LOCAL);

    usb_otg_regfront_lregs #(
        .DATA_W(DATA_W)
    ) u_lregs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (local_wr),
        .sel  (lsel),
        .wdata(bus_wdata),
        .rdata(local_rdata),
        .err  (local_err)
    );

    assign core_valid = bus_valid && (region == RGN_DIRECT || region == RGN_WINDOW);
    assign core_write = core_valid && bus_write;
    assign core_size  = bus_size;
    assign core_wdata = bus_wdata;

    always_comb begin
        bus_rdata = '0;
        bus_err   = 1'b0;
        if (bus_valid) begin
            unique case (region)
                RGN_DIRECT, RGN_WINDOW: bus_rdata = core_rdata;
                RGN_LOCAL: begin
                    bus_rdata = bus_write ? '0 : local_rdata;
                    bus_err   = local_err;
                end
                default: bus_err = 1'b1;
            endcase
        end
    end

    assign irq_out = core_irq;

    assert_direct_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && 32'(bus_addr) < DIRECT_TOP) |-> (32'(core_addr) == 32'(bus_addr)));

    assert_window_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && 32'(bus_addr) >= DIRECT_TOP) |->
        (core_addr[1:0] == 2'b00 && 32'(core_addr) >= WIN_BASE &&
         32'(core_addr) <= WIN_BASE + WIN_MASK));

    assert_no_core_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && 32'(bus_addr) >= WINDOW_TOP) |-> !core_valid);

    assert_err_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_valid);

endmodule

// File: tb/usb_otg_regfront_tb.sv
module usb_otg_regfront_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        core_valid;
    logic        core_write;
    logic [1:0]  core_size;
    logic [8:0]  core_addr;
    logic [31:0] core_wdata;
    logic [31:0] core_rdata;
    logic        core_irq = 1'b0;
    logic        irq_out;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] s_rdata;
    logic        s_err, s_cv, s_cw;
    logic [1:0]  s_csz;
    logic [8:0]  s_caddr;
    logic [31:0] s_cwd;

    always #4 clk = ~clk;

    assign core_rdata = 32'hC0DE_0000 | 32'(core_addr);

    usb_otg_regfront u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .core_valid(core_valid), .core_write(core_write),
        .core_size(core_size), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_irq(core_irq), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [1:0] sz, input logic [11:0] a,
                       input logic [31:0] wd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_size = sz; bus_addr = a; bus_wdata = wd;
        #2;
        s_rdata = bus_rdata; s_err = bus_err; s_cv = core_valid; s_cw = core_write;
        s_csz = core_size; s_caddr = core_addr; s_cwd = core_wdata;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_word(input logic [11:0] a, output logic [31:0] v);
        acc(1'b0, 2'd2, a, 32'h0);
        v = s_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R11 irq low at reset", 32'(irq_out), 32'h0);
        rd_word(12'h404, v); chk("R5 sysconfig reset", v, 32'h0);
        rd_word(12'h40C, v); chk("R5 interfsel reset", v, 32'h1);
        rd_word(12'h410, v); chk("R5 simenable reset", v, 32'h0);
        rd_word(12'h414, v); chk("R5 forcestdby reset", v, 32'h1);
        rd_word(12'h400, v); chk("R3 revision", v, 32'h33);
        chk("R3 revision no err", 32'(s_err), 32'h0);
        rd_word(12'h408, v); chk("R3 sysstatus", v, 32'h1);
    endtask

    task automatic t_direct;
        acc(1'b1, 2'd0, 12'h013, 32'hA5A5_1234);
        chk("R1 core_valid", 32'(s_cv), 32'h1);
        chk("R1 core_write", 32'(s_cw), 32'h1);
        chk("R1 core_size byte", 32'(s_csz), 32'h0);
        chk("R1 core_addr", 32'(s_caddr), 32'h013);
        chk("R1 core_wdata", s_cwd, 32'hA5A5_1234);
        chk("R1 no err", 32'(s_err), 32'h0);
        acc(1'b0, 2'd1, 12'h1FE, 32'h0);
        chk("R1 read size half", 32'(s_csz), 32'h1);
        chk("R1 read dir", 32'(s_cw), 32'h0);
        chk("R1 read data", s_rdata, 32'hC0DE_01FE);
    endtask

    task automatic t_window;
        logic [11:0] addrs [4] = '{12'h200, 12'h288, 12'h3FF, 12'h37C};
        for (int i = 0; i < 4; i++) begin
            logic [31:0] ea;
            ea = 32'h20 + ((32'(addrs[i]) >> 3) & 32'h3C);
            acc(1'b0, 2'd2, addrs[i], 32'h0);
            chk("R2 window core_valid", 32'(s_cv), 32'h1);
            chk("R2 window core_addr", 32'(s_caddr), ea);
            chk("R2 window rdata", s_rdata, 32'hC0DE_0000 | ea);
        end
        acc(1'b1, 2'd1, 12'h288, 32'h0000_BEEF);
        chk("R2 window write size", 32'(s_csz), 32'h1);
        chk("R2 window write dir", 32'(s_cw), 32'h1);
        chk("R2 window wdata", s_cwd, 32'h0000_BEEF);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        acc(1'b1, 2'd2, 12'h400, 32'hFFFF_FFFF);
        chk("R4 revision write err", 32'(s_err), 32'h1);
        acc(1'b1, 2'd2, 12'h408, 32'h0);
        chk("R4 sysstatus write err", 32'(s_err), 32'h1);
        rd_word(12'h400, v); chk("R4 revision kept", v, 32'h33);
        rd_word(12'h408, v); chk("R4 sysstatus kept", v, 32'h1);
        rd_word(12'h404, v); chk("R4 sysconfig untouched", v, 32'h0);
    endtask

    task automatic t_sysconfig;
        logic [31:0] v;
        acc(1'b1, 2'd2, 12'h404, 32'hFFFF_FFFD);
        chk("R6 sysconfig write no err", 32'(s_err), 32'h0);
        rd_word(12'h404, v); chk("R6 sysconfig masked", v, 32'h0000_301D);
        acc(1'b1, 2'd2, 12'h404, 32'h0000_1010);
        rd_word(12'h404, v); chk("R6 sysconfig masked 2", v, 32'h0000_1010);
    endtask

    task automatic t_masks;
        logic [31:0] v;
        acc(1'b1, 2'd2, 12'h40C, 32'hFFFF_FFFE);
        rd_word(12'h40C, v); chk("R8 interfsel mask", v, 32'h2);
        acc(1'b1, 2'd2, 12'h414, 32'hFFFF_FFFE);
        rd_word(12'h414, v); chk("R8 forcestdby mask", v, 32'h0);
        acc(1'b1, 2'd2, 12'h414, 32'h0000_0003);
        rd_word(12'h414, v); chk("R8 forcestdby bit0", v, 32'h1);
        acc(1'b1, 2'd2, 12'h414, 32'h0);
    endtask

    task automatic t_softreset;
        logic [31:0] v;
        acc(1'b1, 2'd2, 12'h40C, 32'h3);
        acc(1'b1, 2'd2, 12'h414, 32'h0);
        acc(1'b1, 2'd2, 12'h404, 32'hF0F2);
        rd_word(12'h40C, v); chk("R7 softreset interfsel", v, 32'h1);
        rd_word(12'h414, v); chk("R7 softreset forcestdby", v, 32'h1);
        rd_word(12'h404, v); chk("R7 softreset sysconfig", v, 32'h0000_3012);
    endtask

    task automatic t_simen;
        logic [31:0] v;
        acc(1'b1, 2'd2, 12'h410, 32'hFFFF_FFFF);
        chk("R9 simenable write err", 32'(s_err), 32'h1);
        chk("R9 no core access", 32'(s_cv), 32'h0);
        rd_word(12'h410, v); chk("R9 simenable stays 0", v, 32'h0);
        chk("R9 read no err", 32'(s_err), 32'h0);
    endtask

    task automatic t_bad;
        logic [31:0] v;
        acc(1'b0, 2'd0, 12'h400, 32'h0);
        chk("R10 byte local rdata", s_rdata, 32'h0);
        chk("R10 byte local err", 32'(s_err), 32'h1);
        chk("R10 byte local no core", 32'(s_cv), 32'h0);
        acc(1'b1, 2'd1, 12'h40C, 32'h0);
        chk("R10 half write err", 32'(s_err), 32'h1);
        rd_word(12'h40C, v); chk("R10 half write ignored", v, 32'h1);
        acc(1'b0, 2'd2, 12'h418, 32'h0);
        chk("R10 unmapped err", 32'(s_err), 32'h1);
        chk("R10 unmapped rdata", s_rdata, 32'h0);
        acc(1'b0, 2'd2, 12'h402, 32'h0);
        chk("R10 unaligned err", 32'(s_err), 32'h1);
        acc(1'b0, 2'd2, 12'hFFC, 32'h0);
        chk("R10 top err", 32'(s_err), 32'h1);
        chk("R10 top no core", 32'(s_cv), 32'h0);
        @(negedge clk); #2;
        chk("R10 err one cycle", 32'(bus_err), 32'h0);
    endtask

    task automatic t_irq;
        @(negedge clk);
        core_irq = 1'b1; #1;
        chk("R11 irq high", 32'(irq_out), 32'h1);
        @(posedge clk); #2;
        chk("R11 irq held", 32'(irq_out), 32'h1);
        core_irq = 1'b0; #1;
        chk("R11 irq low", 32'(irq_out), 32'h0);
    endtask

    initial begin
        #3000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_direct;
        t_window;
        t_readonly;
        t_sysconfig;
        t_masks;
        t_softreset;
        t_simen;
        t_bad;
        t_irq;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule